// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

An 8-bit up-counter clocked from a prescaled peripheral clock. One control bit chooses its job. In watchdog mode, software is expected to reload the counter before it wraps. If the counter wraps anyway, a sticky watchdog flag is set and a reset pulse is sent out. The reset pulse is either power-on or manual, and software picks which. In interval mode, every wrap sets a sticky interval flag, and that flag drives an interrupt request. In both modes the counter keeps running after a wrap.

Software uses a single-cycle write port and a combinational read port. These reach two byte-wide locations: the control/status register and the counter. The reset controller, the interrupt controller and the clock generator are outside this block. The block only drives the active-low reset line, two reset status lines and the interrupt request.

Top module: `wdt_dual_timer`

## Requirements
- R1: After reset the control/status register reads 8'h00, the counter reads 8'h00, `irq` is 0, `rst_out_n` is 1 and `rst_ind` is 2'b00.
- R2: Location 0 (`wr_sel`/`rd_sel` = 0) is the control/status register. Its layout is: bit7 watchdog flag, bit6 interval flag, bit5 mode (1 = watchdog, 0 = interval), bit4 enable, bit3 reset kind (0 = power-on, 1 = manual), bits2:0 clock select. Location 1 is the counter, which takes any written value and reads it back.
- R3: The counter advances only while enable is 1. It advances once every 2^sel peripheral clocks. The first advance comes 2^sel clocks after the write that sets enable, because the prescaler is held at zero while enable is 0.
- R4: A wrap from 8'hFF to 8'h00 on an advance is an overflow. After an overflow the counter keeps counting from 8'h00.
- R5: An overflow in watchdog mode sets bit7. For the length of the reset pulse it drives `rst_out_n` low and both `rst_ind` lines high.
- R6: The reset pulse lasts 2^sel peripheral clocks (one count period) when the kind is power-on. It lasts MAN_CYC (default 5) peripheral clocks when the kind is manual.
- R7: In watchdog mode, writing 8'h00 to the counter restarts the count. Regular rewrites therefore prevent any overflow and any reset pulse.
- R8: An overflow in interval mode sets bit6 and raises `irq`. It produces no reset pulse.
- R9: Both flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. `irq` is high exactly while bit6 is set.
- R10: While enable is 1, writes to the mode bit and the clock-select field are ignored. Enable and reset kind are always writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 1 | Write target: 0 control/status, 1 counter |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 control/status, 1 counter |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | Interval interrupt request |
| rst_out_n | output | 1 | Active-low reset pulse |
| rst_ind | output | 2 | Reset status lines, both high during a pulse |

## Verification
A write takes effect at the single rising edge inside the bench's write task. The next falling edge counts as cycle 0. An overflow after an enabling write with counter value V is visible on the falling edge 2^sel·(256−V) cycles later. At that edge the flag, `irq` or the reset lines are already at their new values. The bench counts falling edges until it sees the flag and compares the count with that formula. It then counts how many falling edges `rst_out_n` stays low and compares that with the pulse length. Finally it reads the counter, whose expected value is floor(pulse/2^sel). All sampling is done on falling edges, so no result is taken at the edge where it changes.

// File: rtl/wdt_dual_timer.sv
module wdt_dual_timer #(
  parameter int SEL_STEP = 1,
  parameter int MAN_CYC  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       rst_out_n,
  output logic [1:0] rst_ind
);
  localparam int PS_W = 7 * SEL_STEP;
  localparam int PL_W = PS_W + 4;

  logic [PS_W-1:0] ps_q;
  logic [7:0]      cnt_q;
  logic            wovf_q, iovf_q, mode_q, en_q, kind_q;
  logic [2:0]      sel_q;
  logic [PL_W-1:0] pulse_q;

  wire             wr_ctrl = wr_en && !wr_sel;
  wire             wr_cnt  = wr_en &&  wr_sel;
  wire [PS_W-1:0]  ps_mask = ~({PS_W{1'b1}} << (sel_q * SEL_STEP));
  wire             tick    = en_q && ((ps_q & ps_mask) == ps_mask);
  wire             ovf     = tick && (cnt_q == 8'hFF) && !wr_cnt;
  wire [PL_W-1:0]  len     = kind_q ? PL_W'(MAN_CYC) : (PL_W'(1) << (sel_q * SEL_STEP));
  wire             active  = (pulse_q != '0);

  assign rd_data   = rd_sel ? cnt_q : {wovf_q, iovf_q, mode_q, en_q, kind_q, sel_q};
  assign irq       = iovf_q;
  assign rst_out_n = !active;
  assign rst_ind   = {2{active}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ps_q <= '0;
    else if (!en_q)   ps_q <= '0;
    else              ps_q <= ps_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_cnt)  cnt_q <= wr_data;
    else if (tick)    cnt_q <= cnt_q + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wovf_q <= 1'b0; iovf_q <= 1'b0; mode_q <= 1'b0;
      en_q   <= 1'b0; kind_q <= 1'b0; sel_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        wovf_q <= wovf_q & wr_data[7];
        iovf_q <= iovf_q & wr_data[6];
        en_q   <= wr_data[4];
        kind_q <= wr_data[3];
        if (!en_q) begin
          mode_q <= wr_data[5];
          sel_q  <= wr_data[2:0];
        end
      end
      if (ovf &&  mode_q) wovf_q <= 1'b1;
      if (ovf && !mode_q) iovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pulse_q <= '0;
    else if (ovf && mode_q)  pulse_q <= len;
    else if (active)         pulse_q <= pulse_q - 1'b1;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == 8'h00) && (wovf_q || iovf_q)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_cnt) |=> $stable(cnt_q)); // R3
  AST_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> ($stable(mode_q) && $stable(sel_q))); // R10
  AST_RESET_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> wovf_q); // R5
  AST_IRQ_INTERVAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !mode_q); // R8
endmodule

// File: tb/wdt_dual_timer_tb_top.sv
`timescale 1ns/100ps
module wdt_dual_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq, rst_out_n;
  logic [1:0] rst_ind;
  int         vectors = 0, miscompares = 0;

  always #2 clk = ~clk;

  wdt_dual_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .rst_out_n(rst_out_n), .rst_ind(rst_ind));

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    rd_sel = s;
    #0.5;
    d = rd_data;
    rd_sel = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input bit wf, input bit iff_, input bit md,
                                     input bit en, input bit kd, input int sl);
    return {wf, iff_, md, en, kd, 3'(sl)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, w, dv, len, t;
    bit seen_low;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(1'b0, d); check("R1 ctrl", d, 0);
    rd(1'b1, d); check("R1 cnt", d, 0);
    check("R1 irq", irq, 0);
    check("R1 rst_out_n", rst_out_n, 1);
    check("R1 rst_ind", rst_ind, 0);

    for (int v = 0; v < 256; v++) begin
      wr(1'b1, 8'(v)); rd(1'b1, d); check("R2 cnt readback", d, v);
    end
    for (int c = 0; c < 32; c++) begin
      wr(1'b0, ctl(0, 0, c[4], 0, c[3], c[2:0]));
      rd(1'b0, d); check("R2 ctrl readback", d, ctl(0, 0, c[4], 0, c[3], c[2:0]));
    end

    wr(1'b1, 8'h10);
    repeat (50) @(negedge clk);
    rd(1'b1, d); check("R3 disabled hold", d, 8'h10);

    for (int k = 0; k < 2; k++) begin
      for (int s = 0; s < 8; s++) begin
        dv = 1 << s;
        len = k ? 5 : dv;
        t = dv * 4;
        wr(1'b1, 8'hFC);
        wr(1'b0, ctl(0, 0, 1, 1, k[0], s));
        n = 0; d = 0;
        while (!d[7] && n < 4 * t) begin
          @(negedge clk); n++; rd(1'b0, d);
        end
        check("R3 overflow cycle", n, t);
        check("R5 rst_out_n low", rst_out_n, 0);
        check("R5 rst_ind high", rst_ind, 3);
        check("R5 irq quiet", irq, 0);
        w = 0;
        while (!rst_out_n && w < 1000) begin
          w++; @(negedge clk);
        end
        check("R6 pulse width", w, len);
        rd(1'b1, d); check("R4 keeps counting", d, w / dv);
        wr(1'b0, ctl(0, 0, 1, 0, k[0], s));
        rd(1'b0, d); check("R9 wd flag cleared", d, ctl(0, 0, 1, 0, k[0], s));
      end
    end

    for (int s = 0; s < 8; s++) begin
      dv = 1 << s;
      t = dv * 4;
      wr(1'b1, 8'hFC);
      wr(1'b0, ctl(0, 0, 0, 1, 0, s));
      n = 0; d = 0; seen_low = 0;
      while (!d[6] && n < 4 * t) begin
        @(negedge clk); n++; rd(1'b0, d);
        if (!rst_out_n) seen_low = 1;
      end
      check("R8 interval overflow cycle", n, t);
      check("R8 irq raised", irq, 1);
      repeat (2 * dv) begin
        @(negedge clk);
        if (!rst_out_n) seen_low = 1;
      end
      check("R8 no reset pulse", seen_low, 0);
      check("R9 irq sticky", irq, 1);
      wr(1'b0, ctl(1, 1, 0, 1, 0, s));
      check("R9 write one keeps flag", irq, 1);
      rd(1'b0, d); check("R9 wd flag not set by write", d[7], 0);
      wr(1'b0, ctl(0, 0, 0, 0, 0, s));
      check("R9 irq cleared", irq, 0);
    end

    wr(1'b1, 8'h00);
    wr(1'b0, ctl(0, 0, 1, 1, 0, 0));
    seen_low = 0;
    for (int i = 0; i < 6; i++) begin
      repeat (200) begin
        @(negedge clk);
        if (!rst_out_n) seen_low = 1;
      end
      wr(1'b1, 8'h00);
    end
    rd(1'b0, d); check("R7 no flag while kicked", d[7], 0);
    check("R7 no pulse while kicked", seen_low, 0);
    n = 0; d = 0;
    while (!d[7] && n < 1000) begin
      @(negedge clk); n++; rd(1'b0, d);
    end
    check("R7 overflow after last kick", n, 256);
    wr(1'b0, ctl(0, 0, 1, 0, 0, 0));
    repeat (4) @(negedge clk);

    wr(1'b0, ctl(0, 0, 0, 1, 0, 2));
    wr(1'b0, ctl(0, 0, 1, 1, 1, 5));
    rd(1'b0, d); check("R10 locked while enabled", d, ctl(0, 0, 0, 1, 1, 2));
    wr(1'b0, ctl(0, 0, 1, 0, 0, 5));
    rd(1'b0, d); check("R10 disabling write still locked", d, ctl(0, 0, 0, 0, 0, 2));
    wr(1'b0, ctl(0, 0, 1, 0, 0, 5));
    rd(1'b0, d); check("R10 unlocked when disabled", d, ctl(0, 0, 1, 0, 0, 5));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule